// File: doc/BRIEF.md
# RTC Prescaler with Trimmed Seconds Tick

This block turns a 32768 Hz timebase into a once-per-second tick for a real-time clock. The slow timebase arrives as a one-cycle enable (`tick_en_i`) on a faster system clock. A first counter divides the enabled ticks by 256. A second counter, stepped on each wrap of the first, divides by 128. The end of each second is flagged by a single-cycle pulse on `sec_tick_o`.

A test output helps when measuring and trimming the crystal. It carries a 512 Hz or a 256 Hz square wave from the first counter, or a 1 Hz wave from the second counter. It can also be turned off. A signed six-bit trim value lengthens or shortens chosen seconds by one whole first-stage period, which is 256 input ticks. These adjusted seconds are spread evenly over a correction window of 3840 seconds. Slowing costs one adjusted second per trim unit, about +2 ppm. Speeding up costs two, about -4 ppm. Only the seconds path and the 1 Hz test wave are trimmed.

A hold input freezes both counters and the trim scheduler. Counting resumes from the frozen state when hold drops.

Top module: `rtc_prescale_trim`

## Requirements
- R1: While `rst_ni` is low, all counters, the window position and the trim accumulator are cleared, and `sec_tick_o` and `test_clk_o` are 0. With trim zero, the first tick appears STAGE0_DIV*STAGE1_DIV enabled ticks after reset is released.
- R2: The counters advance only on clock edges where `tick_en_i` is 1 and `hold_i` is 0. With trim zero, `sec_tick_o` is a one-cycle pulse every STAGE0_DIV*STAGE1_DIV enabled ticks. The pulse appears on the cycle after the edge that ends the second.
- R3: The test tap select takes four values. `tap_sel_i`=01 gives the first-stage count bit of period STAGE0_DIV/4 ticks. 10 gives the bit of period STAGE0_DIV/2 ticks. Both are 50% duty. 11 gives a wave that is high while the second-stage count is at least STAGE1_DIV/2. `test_clk_o` is registered, so it follows the counters one clock later.
- R4: With `tap_sel_i`=00, `test_clk_o` is held at 0.
- R5: The 01 and 10 test taps keep their untrimmed period for any trim setting.
- R6: An adjusted second lasts (STAGE1_DIV+1)*STAGE0_DIV ticks when `trim_sign_i`=0 (slow down). It lasts (STAGE1_DIV-1)*STAGE0_DIV ticks when `trim_sign_i`=1 (speed up). Every other second lasts STAGE1_DIV*STAGE0_DIV ticks.
- R7: The number of adjusted seconds per window is n = `trim_mag_i`*1 for slow-down and n = `trim_mag_i`*2 for speed-up. Seconds are picked by an accumulator that adds n at every second boundary and restarts at each window boundary. With a constant setting, any WINDOW_SECS consecutive seconds after two full windows hold exactly n adjusted seconds.
- R8: While `hold_i` is 1, no tick occurs and the counters keep their values. After release, the pending second completes with its remaining count, so the tick is delayed by exactly the number of held cycles.
- R9: The trim inputs are sampled only at second boundaries. They decide whether the next second is adjusted, and in which direction. A change in mid-second does not alter the length of the running second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | One-cycle enable per 32768 Hz timebase tick |
| hold_i | input | 1 | Freezes both divider stages and the trim scheduler |
| tap_sel_i | input | 2 | Test output select: 00 off, 01 fast tap, 10 slow tap, 11 seconds wave |
| trim_sign_i | input | 1 | Trim direction: 0 slows the seconds tick, 1 speeds it up |
| trim_mag_i | input | MAG_W (6) | Trim magnitude in units |
| sec_tick_o | output | 1 | One-cycle pulse at the end of each second |
| test_clk_o | output | 1 | Selected test waveform, registered |

## Verification
The bench builds the block with STAGE0_DIV=16, STAGE1_DIV=4 and WINDOW_SECS=128. A second is then 64 enabled ticks, and a full correction window is 8192 cycles. This puts several complete windows within reach, so the per-window adjusted-second count and the lengths of both kinds of adjusted second can be measured directly. The small divisors also make the fast and slow taps short enough to time the period of each one. A random phase varies the tick enable, hold, select and trim while a cycle-level model checks both outputs on every cycle.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;
  typedef enum logic [1:0] {
    TAP_OFF  = 2'b00,
    TAP_FAST = 2'b01,
    TAP_SLOW = 2'b10,
    TAP_SEC  = 2'b11
  } tap_sel_e;
endpackage

// File: rtl/rtc_stage0.sv
module rtc_stage0 #(
  parameter int DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic wrap_o,
  output logic fast_tap_o,
  output logic slow_tap_o
);
  localparam int W = $clog2(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (step_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign wrap_o     = step_i && (cnt_q == LAST);
  // taps are bits of the untrimmed count: period DIV/4 and DIV/2
  assign fast_tap_o = cnt_q[W-3];
  assign slow_tap_o = cnt_q[W-2];

  p_hold_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_stage1.sv
module rtc_stage1 #(
  parameter int DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic adj_i,
  input  logic fast_i,
  output logic sec_end_o,
  output logic upper_half_o
);
  localparam int CW = $clog2(DIV + 1);
  localparam logic [CW-1:0] L_NORM  = CW'(DIV - 1);
  localparam logic [CW-1:0] L_LONG  = CW'(DIV);
  localparam logic [CW-1:0] L_SHORT = CW'(DIV - 2);
  localparam logic [CW-1:0] HALF    = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb begin
    if (!adj_i)      last = L_NORM;
    else if (fast_i) last = L_SHORT;
    else             last = L_LONG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (step_i) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  assign sec_end_o    = step_i && (cnt_q == last);
  assign upper_half_o = (cnt_q >= HALF);

  p_cnt1_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= L_LONG);
endmodule

// File: rtl/rtc_trim_sched.sv
module rtc_trim_sched #(
  parameter int WINDOW_SECS = 3840,
  parameter int MAG_W       = 6,
  parameter int SLOW_EV     = 1,
  parameter int FAST_EV     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_end_i,
  input  logic             sign_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             adj_o,
  output logic             fast_o
);
  localparam int AW = $clog2(WINDOW_SECS + FAST_EV * (2 ** MAG_W)) + 1;
  localparam int WW = $clog2(WINDOW_SECS);
  localparam logic [AW-1:0] K_SLOW   = AW'(SLOW_EV);
  localparam logic [AW-1:0] K_FAST   = AW'(FAST_EV);
  localparam logic [AW-1:0] WIN      = AW'(WINDOW_SECS);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_SECS - 1);

  logic [WW-1:0] win_q;
  logic [AW-1:0] acc_q;
  logic          adj_q, fast_q;
  logic [AW-1:0] n, base, sum;
  logic          hit;

  always_comb begin
    n    = AW'(mag_i) * (sign_i ? K_FAST : K_SLOW);
    base = (win_q == WIN_LAST) ? '0 : acc_q;
    sum  = base + n;
    hit  = (sum >= WIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      acc_q  <= '0;
      adj_q  <= 1'b0;
      fast_q <= 1'b0;
    end else if (sec_end_i) begin
      win_q  <= (win_q == WIN_LAST) ? '0 : win_q + 1'b1;
      acc_q  <= hit ? sum - WIN : sum;
      adj_q  <= hit;
      fast_q <= sign_i;
    end
  end

  assign adj_o  = adj_q;
  assign fast_o = fast_q;

  p_acc_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < WIN);
  p_adj_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_end_i |=> $stable({adj_q, fast_q}));
endmodule

// File: rtl/rtc_tap_mux.sv
module rtc_tap_mux
  import rtc_presc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] tap_sel_i,
  input  logic       fast_i,
  input  logic       slow_i,
  input  logic       sec_i,
  output logic       test_clk_o
);
  tap_sel_e sel;
  logic     nxt, out_q;

  assign sel = tap_sel_e'(tap_sel_i);

  always_comb begin
    unique case (sel)
      TAP_FAST: nxt = fast_i;
      TAP_SLOW: nxt = slow_i;
      TAP_SEC:  nxt = sec_i;
      default:  nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= nxt;
  end

  assign test_clk_o = out_q;

  p_off_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_sel_i == TAP_OFF) |=> !test_clk_o);
endmodule

// File: rtl/rtc_prescale_trim.sv
module rtc_prescale_trim #(
  parameter int STAGE0_DIV  = 256,
  parameter int STAGE1_DIV  = 128,
  parameter int WINDOW_SECS = 3840,
  parameter int MAG_W       = 6,
  parameter int SLOW_EV     = 1,
  parameter int FAST_EV     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             hold_i,
  input  logic [1:0]       tap_sel_i,
  input  logic             trim_sign_i,
  input  logic [MAG_W-1:0] trim_mag_i,
  output logic             sec_tick_o,
  output logic             test_clk_o
);
  logic step0, wrap0, fast_tap, slow_tap;
  logic sec_end, sec_half, adj, adj_fast;
  logic tick_q;

  assign step0 = tick_en_i && !hold_i;

  rtc_stage0 #(.DIV(STAGE0_DIV)) u_stage0 (
    .clk_i, .rst_ni, .step_i(step0), .wrap_o(wrap0),
    .fast_tap_o(fast_tap), .slow_tap_o(slow_tap)
  );

  rtc_stage1 #(.DIV(STAGE1_DIV)) u_stage1 (
    .clk_i, .rst_ni, .step_i(wrap0), .adj_i(adj), .fast_i(adj_fast),
    .sec_end_o(sec_end), .upper_half_o(sec_half)
  );

  rtc_trim_sched #(
    .WINDOW_SECS(WINDOW_SECS), .MAG_W(MAG_W),
    .SLOW_EV(SLOW_EV), .FAST_EV(FAST_EV)
  ) u_trim (
    .clk_i, .rst_ni, .sec_end_i(sec_end), .sign_i(trim_sign_i),
    .mag_i(trim_mag_i), .adj_o(adj), .fast_o(adj_fast)
  );

  rtc_tap_mux u_mux (
    .clk_i, .rst_ni, .tap_sel_i, .fast_i(fast_tap), .slow_i(slow_tap),
    .sec_i(sec_half), .test_clk_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= sec_end;
  end

  assign sec_tick_o = tick_q;

  p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);
  p_hold_no_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !sec_tick_o);
endmodule

// File: tb/rtc_prescale_trim_test.sv
module rtc_prescale_trim_test;
  localparam int S0  = 16;
  localparam int S1  = 4;
  localparam int WS  = 128;
  localparam int S0W = $clog2(S0);
  localparam int SEC = S0 * S1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       hold = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       sgn = 1'b0;
  logic [5:0] mag = '0;
  logic       sec_tick, test_clk;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtc_prescale_trim #(.STAGE0_DIV(S0), .STAGE1_DIV(S1), .WINDOW_SECS(WS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .hold_i(hold),
    .tap_sel_i(sel), .trim_sign_i(sgn), .trim_mag_i(mag),
    .sec_tick_o(sec_tick), .test_clk_o(test_clk)
  );

  // cycle-level reference built from the requirements
  int m_c0, m_c1, m_win, m_acc;
  bit m_adj, m_dir, exp_tick, exp_tc;

  function automatic int sec_len_periods(bit adj, bit dir);
    if (!adj) return S1;
    return dir ? S1 - 1 : S1 + 1;
  endfunction

  function automatic bit tap_value(int s, int c0, int c1);
    case (s)
      1: return bit'((c0 >> (S0W - 3)) & 1);
      2: return bit'((c0 >> (S0W - 2)) & 1);
      3: return c1 >= S1 / 2;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_step();
    int base, n, sum;
    exp_tick = 1'b0;
    exp_tc   = tap_value(int'(sel), m_c0, m_c1);
    if (tick_en && !hold) begin
      if (m_c0 == S0 - 1) begin
        m_c0 = 0;
        if (m_c1 == sec_len_periods(m_adj, m_dir) - 1) begin
          exp_tick = 1'b1;
          m_c1 = 0;
          base = (m_win == WS - 1) ? 0 : m_acc;
          n    = int'(mag) * (sgn ? 2 : 1);
          sum  = base + n;
          m_adj = (sum >= WS);
          m_acc = m_adj ? sum - WS : sum;
          m_dir = sgn;
          m_win = (m_win == WS - 1) ? 0 : m_win + 1;
        end else m_c1++;
      end else m_c0++;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c0 = 0; m_c1 = 0; m_win = 0; m_acc = 0;
      m_adj = 0; m_dir = 0; exp_tick = 0; exp_tc = 0;
    end else model_step();
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(sec_tick == exp_tick, "R2", "sec_tick vs model", sec_tick, exp_tick);
      check(test_clk == exp_tc, "R3", "test_clk vs model", test_clk, exp_tc);
    end
  end

  task automatic next_tick(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!sec_tick);
  endtask

  task automatic tap_period(output int per, output int high);
    bit prev;
    prev = test_clk;
    do begin
      @(negedge clk);
      if (test_clk && !prev) break;
      prev = test_clk;
    end while (1);
    per = 0; high = 0;
    prev = 1'b1;
    do begin
      if (test_clk) high++;
      @(negedge clk);
      per++;
      if (test_clk && !prev) break;
      prev = test_clk;
    end while (per < 1000);
  endtask

  task automatic trim_window(bit s, int m, string req_len, string req_cnt);
    int c, total, nadj, exp_n, delta;
    @(negedge clk);
    sgn = s; mag = 6'(m); sel = 2'b01;
    for (int i = 0; i < 2 * WS + 2; i++) next_tick(c);
    total = 0; nadj = 0;
    exp_n = s ? 2 * m : m;
    delta = s ? -S0 : S0;
    for (int i = 0; i < WS; i++) begin
      next_tick(c);
      total += c;
      if (c != SEC) begin
        nadj++;
        check(c == SEC + delta, req_len, "adjusted second length", c, SEC + delta);
      end
    end
    check(nadj == exp_n, req_cnt, "adjusted seconds per window", nadj, exp_n);
    check(total == WS * SEC + exp_n * delta, req_cnt, "window length", total,
          WS * SEC + exp_n * delta);
  endtask

  initial begin : main
    int c, c2, per, high;
    bit held;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(sec_tick == 1'b0, "R1", "sec_tick in reset", sec_tick, 0);
    check(test_clk == 1'b0, "R1", "test_clk in reset", test_clk, 0);
    rst_n = 1'b1;
    next_tick(c);
    check(c == SEC, "R1", "first tick after release", c, SEC);
    next_tick(c);
    check(c == SEC, "R2", "untrimmed period", c, SEC);

    // half-rate tick enable
    fork
      begin
        for (int i = 0; i < 3 * 2 * SEC; i++) begin
          @(negedge clk);
          tick_en = ~tick_en;
        end
      end
      begin
        next_tick(c);
        next_tick(c);
        check(c == 2 * SEC, "R2", "period with half-rate enable", c, 2 * SEC);
      end
    join_any
    wait fork;
    @(negedge clk); tick_en = 1'b1;

    sel = 2'b01;
    tap_period(per, high);
    check(per == S0 / 4, "R3", "fast tap period", per, S0 / 4);
    check(high == S0 / 8, "R3", "fast tap high time", high, S0 / 8);
    @(negedge clk); sel = 2'b10;
    tap_period(per, high);
    check(per == S0 / 2, "R3", "slow tap period", per, S0 / 2);
    check(high == S0 / 4, "R3", "slow tap high time", high, S0 / 4);
    @(negedge clk); sel = 2'b11;
    tap_period(per, high);
    check(per == SEC, "R3", "seconds tap period", per, SEC);
    check(high == SEC / 2, "R3", "seconds tap high time", high, SEC / 2);
    @(negedge clk); sel = 2'b00;
    @(negedge clk);
    high = 0;
    for (int i = 0; i < 3 * SEC; i++) begin
      @(negedge clk);
      if (test_clk) high++;
    end
    check(high == 0, "R4", "output high cycles with tap off", high, 0);

    // hold delays the pending second by exactly the held cycles
    sel = 2'b01;
    next_tick(c);
    c = 0;
    repeat (10) begin @(negedge clk); c++; end
    hold = 1'b1;
    @(negedge clk); c++;
    held = test_clk;
    for (int i = 1; i < 37; i++) begin
      @(negedge clk); c++;
      check(!sec_tick, "R8", "tick during hold", sec_tick, 0);
      check(test_clk == held, "R8", "tap frozen during hold", test_clk, held);
    end
    hold = 1'b0;
    next_tick(c2);
    check(c + c2 == SEC + 37, "R8", "tick delay after hold", c + c2, SEC + 37);

    trim_window(1'b0, 5, "R6", "R7");
    tap_period(per, high);
    check(per == S0 / 4, "R5", "fast tap period under slow trim", per, S0 / 4);
    trim_window(1'b1, 3, "R6", "R7");
    @(negedge clk); sel = 2'b10;
    tap_period(per, high);
    check(per == S0 / 2, "R5", "slow tap period under fast trim", per, S0 / 2);

    // R9: trim change in mid-second keeps the running second's length
    @(negedge clk); sgn = 1'b0; mag = 6'd63;
    next_tick(c);
    repeat (5) next_tick(c);
    repeat (S0) @(negedge clk);
    sgn = 1'b1; mag = 6'd0;
    next_tick(c2);
    check(c2 + S0 == SEC || c2 + S0 == SEC + S0, "R9", "mid-second change length",
          c2 + S0, SEC);

    // random phase, checked cycle by cycle against the model
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      tick_en = ($urandom_range(0, 9) < 8);
      if ($urandom_range(0, 49) == 0) begin
        sel  = 2'($urandom_range(0, 3));
        sgn  = 1'($urandom_range(0, 1));
        mag  = 6'($urandom_range(0, 63));
        hold = ($urandom_range(0, 9) == 0);
      end
    end
    hold = 1'b0;

    // reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0; sgn = 1'b0; mag = '0;
    @(negedge clk);
    check(sec_tick == 1'b0, "R1", "sec_tick after mid-run reset", sec_tick, 0);
    check(test_clk == 1'b0, "R1", "test_clk after mid-run reset", test_clk, 0);
    tick_en = 1'b1;
    rst_n = 1'b1;
    next_tick(c);
    check(c == SEC, "R1", "first tick after mid-run reset", c, SEC);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual %0d cycles expected completion earlier", 195000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule